// File: doc/BRIEF.md
# Retention-aware power domain sequencer

This block walks one switchable power domain through its power-up and power-down steps as a hardware state machine. The domain's state-retention flip-flops need extra save and restore steps, and these steps depend on a domain type. The type is given as an input and is captured when a sequence starts. A start-on or start-off request launches a sequence. The block drives a single control word that carries supply-enable, isolation, clock-disable, reset, retention save, retention restore and saved-flag bits. It raises `busy_o` while a sequence runs and pulses `done_o` when the sequence ends.

The restore step on power-up is conditional. Firmware or another agent can change the retention-saved status, so for two of the types the block reads the `saved_flag_i` input once after reset release and decides from that value. One domain type needs settle waits around isolation changes. These waits come from down-counters whose cycle counts are derived from the clock frequency parameter.

Top module: `retn_pd_seq`

## Requirements
- R1: While reset is held and after it is released, the control word is 0x0200000C. That is isolation (bit 2), main clock disable (bit 3) and the active-low restore line (bit 25) set, and every other bit clear. `busy_o` and `done_o` are low.
- R2: A power-up applies these changes one clock apart: set supply enable (bit 0), set secondary enable (bit 1), clear main clock disable (bit 3), clear isolation (bit 2), set reset release (bit 4). One decision cycle follows. For type 0 (no retention hardware) the sequence then ends.
- R3: For type 2 (PCIe PHY), power-up sets the retention clock disable (bit 26) before the main clock disable is cleared. It then holds for ON_WAIT_CYC = CLK_MHZ*ON_SETTLE_US cycles between clearing isolation and releasing reset.
- R4: `saved_flag_i` is sampled only in the cycle right after reset release. Types 1 (generic) and 2 restore only if that sample is 1. Type 3 (UFS storage) always restores. Type 0 never restores. Later changes of the input have no effect.
- R5: The type 1 restore applies, one clock apart: clear saved flag (bit 27), set bit 26, clear bit 25, set bit 25, clear bit 26.
- R6: The type 2 restore applies, one clock apart: clear bit 27, clear bit 25, set bit 25, clear bit 26. Bit 26 is not set again.
- R7: The type 3 restore applies, one clock apart: set the UFS retention clock disable (bit 28), clear bit 25, set bit 25, clear bit 28.
- R8: For types 1 and 2, power-down starts with, one clock apart: set bit 26, set retention save (bit 24), clear bit 24, clear bit 26, set bit 27.
- R9: For type 3, power-down starts with: set bit 28, set bit 24, clear bit 24, clear bit 28. Bit 27 is not set. Type 0 skips the save steps.
- R10: Power-down then sets isolation. For type 2 only, it waits OFF_WAIT_CYC = CLK_MHZ*OFF_SETTLE_US cycles. It then applies, one clock apart: set bit 3, clear bit 4, clear bit 1, clear bit 0.
- R11: `busy_o` is high from the cycle after an accepted request until the last step is applied. `done_o` is high for exactly the following cycle, with `busy_o` low. Between sequences the control word holds its value.
- R12: A request is accepted only when the block is idle. If both requests are present while idle, power-up wins. Requests and type changes that arrive while busy have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dom_type_i | input | 2 | Domain type: 0 none, 1 generic, 2 PCIe PHY, 3 UFS storage |
| on_req_i | input | 1 | Start power-up request |
| off_req_i | input | 1 | Start power-down request |
| saved_flag_i | input | 1 | Retention-saved status read back from the domain |
| ctl_o | output | 32 | Domain control word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Every power-up and power-down is run for each of the four types. Power-ups are run with the saved-flag input at 0 and at 1, and the flag is inverted right after the decision cycle. This separates conditional restore from unconditional restore, and sampling once from continuous sampling. Each run is compared against a bench model on the exact cycle of every control-word change, so a swapped step, a missing settle wait or a wrong wait length shows up directly. Random runs add stray requests and type changes during a sequence, plus a simultaneous on/off request from idle. These show whether the block ignores input while busy and whether power-up takes priority.

// File: rtl/retn_pd_pkg.sv
// Shared types for the retention-aware power domain sequencer.
// Holds the domain type encoding, the control word bit map, the step
// encoding and the per-step set/clear masks. Assumes CTL_W > B_UCLKOFF.
package retn_pd_pkg;

    parameter int CTL_W = 32;

    // Control word bit map
    localparam int B_ON      = 0;
    localparam int B_ON2     = 1;
    localparam int B_ISO     = 2;
    localparam int B_CLKOFF  = 3;
    localparam int B_RSTN    = 4;
    localparam int B_RSAVE   = 24;
    localparam int B_RNRST   = 25;
    localparam int B_RCLKOFF = 26;
    localparam int B_RFLAG   = 27;
    localparam int B_UCLKOFF = 28;

    typedef enum logic [1:0] {
        DOM_PLAIN    = 2'd0,
        DOM_GENERIC  = 2'd1,
        DOM_PCIE_PHY = 2'd2,
        DOM_UFS      = 2'd3
    } dom_type_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_ON_PWR, ST_ON_PWR2, ST_ON_RCLK, ST_ON_CLK, ST_ON_ISO,
        ST_ON_WAIT, ST_ON_RST, ST_ON_CHK,
        ST_RS_PRE, ST_RS_GCLK, ST_RS_LO, ST_RS_HI, ST_RS_POST,
        ST_SV_PRE, ST_SV_HI, ST_SV_LO, ST_SV_POST, ST_SV_FLAG,
        ST_OF_ISO, ST_OF_WAIT, ST_OF_CLK, ST_OF_RST, ST_OF_PWR2, ST_OF_PWR
    } step_e;

    typedef struct packed {
        logic [CTL_W-1:0] set;
        logic [CTL_W-1:0] clr;
    } mask_t;

    // Bits a step sets and clears, given the captured domain type.
    function automatic mask_t step_mask(step_e st, dom_type_e ty);
        mask_t m;
        logic  ufs;
        m.set = '0;
        m.clr = '0;
        ufs   = (ty == DOM_UFS);
        case (st)
            ST_ON_PWR:  m.set[B_ON]      = 1'b1;
            ST_ON_PWR2: m.set[B_ON2]     = 1'b1;
            ST_ON_RCLK: m.set[B_RCLKOFF] = 1'b1;
            ST_ON_CLK:  m.clr[B_CLKOFF]  = 1'b1;
            ST_ON_ISO:  m.clr[B_ISO]     = 1'b1;
            ST_ON_RST:  m.set[B_RSTN]    = 1'b1;
            ST_RS_PRE: begin
                if (ufs) m.set[B_UCLKOFF] = 1'b1;
                else     m.clr[B_RFLAG]   = 1'b1;
            end
            ST_RS_GCLK: m.set[B_RCLKOFF] = 1'b1;
            ST_RS_LO:   m.clr[B_RNRST]   = 1'b1;
            ST_RS_HI:   m.set[B_RNRST]   = 1'b1;
            ST_RS_POST: begin
                if (ufs) m.clr[B_UCLKOFF] = 1'b1;
                else     m.clr[B_RCLKOFF] = 1'b1;
            end
            ST_SV_PRE: begin
                if (ufs) m.set[B_UCLKOFF] = 1'b1;
                else     m.set[B_RCLKOFF] = 1'b1;
            end
            ST_SV_HI:   m.set[B_RSAVE]   = 1'b1;
            ST_SV_LO:   m.clr[B_RSAVE]   = 1'b1;
            ST_SV_POST: begin
                if (ufs) m.clr[B_UCLKOFF] = 1'b1;
                else     m.clr[B_RCLKOFF] = 1'b1;
            end
            ST_SV_FLAG: m.set[B_RFLAG]   = 1'b1;
            ST_OF_ISO:  m.set[B_ISO]     = 1'b1;
            ST_OF_CLK:  m.set[B_CLKOFF]  = 1'b1;
            ST_OF_RST:  m.clr[B_RSTN]    = 1'b1;
            ST_OF_PWR2: m.clr[B_ON2]     = 1'b1;
            ST_OF_PWR:  m.clr[B_ON]      = 1'b1;
            default: ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/retn_wait_cnt.sv
// Settle-wait down-counter.
// Loaded with (cycles-1) on the edge that enters a wait step, it then
// counts down while the wait step is active; zero_o ends the wait.
// Assumes load_i and run_i are never active in the same cycle.
module retn_wait_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         run_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Count register: load, then decrement to zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load_i)                  cnt_q <= load_val_i;
        else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R3: an idle counter keeps its value
    a_r3_cnt_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> $stable(cnt_q));

endmodule

// File: rtl/retn_seq_fsm.sv
// Step sequencer for one retention-aware power domain.
// Accepts a request only when idle (power-up has priority), captures the
// domain type at acceptance, walks the steps for that type, runs the
// settle waits through a shared counter and pulses done after the last
// step. Assumes ON_WAIT_CYC and OFF_WAIT_CYC are at least 1.
module retn_seq_fsm
    import retn_pd_pkg::*;
#(
    parameter int ON_WAIT_CYC  = 625,
    parameter int OFF_WAIT_CYC = 125
) (
    input  logic      clk,
    input  logic      rst_n,
    input  dom_type_e dom_i,
    input  logic      on_req_i,
    input  logic      off_req_i,
    input  logic      saved_flag_i,
    output step_e     step_o,
    output dom_type_e dom_o,
    output logic      busy_o,
    output logic      done_o
);

    localparam int MAXW = (ON_WAIT_CYC > OFF_WAIT_CYC) ? ON_WAIT_CYC : OFF_WAIT_CYC;
    localparam int CW   = $clog2(MAXW + 1);

    step_e           step_q, step_d;
    dom_type_e       dom_q, eff_ty;
    logic            done_q;
    logic            want_restore;
    logic            is_pcie, is_ufs, is_gen;
    logic            wait_load, wait_run, wait_zero;
    logic [CW-1:0]   wait_val;

    // Type in force: live input while idle, captured value otherwise.
    always_comb begin
        eff_ty       = (step_q == ST_IDLE) ? dom_i : dom_q;
        is_pcie      = (eff_ty == DOM_PCIE_PHY);
        is_ufs       = (eff_ty == DOM_UFS);
        is_gen       = (eff_ty == DOM_GENERIC);
        want_restore = is_ufs || ((is_gen || is_pcie) && saved_flag_i);
    end

    // Next-step selection.
    always_comb begin
        step_d = step_q;
        case (step_q)
            ST_IDLE: begin
                if (on_req_i)       step_d = ST_ON_PWR;
                else if (off_req_i) step_d = (eff_ty == DOM_PLAIN) ? ST_OF_ISO : ST_SV_PRE;
            end
            ST_ON_PWR:  step_d = ST_ON_PWR2;
            ST_ON_PWR2: step_d = is_pcie ? ST_ON_RCLK : ST_ON_CLK;
            ST_ON_RCLK: step_d = ST_ON_CLK;
            ST_ON_CLK:  step_d = ST_ON_ISO;
            ST_ON_ISO:  step_d = is_pcie ? ST_ON_WAIT : ST_ON_RST;
            ST_ON_WAIT: step_d = wait_zero ? ST_ON_RST : ST_ON_WAIT;
            ST_ON_RST:  step_d = ST_ON_CHK;
            ST_ON_CHK:  step_d = want_restore ? ST_RS_PRE : ST_IDLE;
            ST_RS_PRE:  step_d = is_gen ? ST_RS_GCLK : ST_RS_LO;
            ST_RS_GCLK: step_d = ST_RS_LO;
            ST_RS_LO:   step_d = ST_RS_HI;
            ST_RS_HI:   step_d = ST_RS_POST;
            ST_RS_POST: step_d = ST_IDLE;
            ST_SV_PRE:  step_d = ST_SV_HI;
            ST_SV_HI:   step_d = ST_SV_LO;
            ST_SV_LO:   step_d = ST_SV_POST;
            ST_SV_POST: step_d = is_ufs ? ST_OF_ISO : ST_SV_FLAG;
            ST_SV_FLAG: step_d = ST_OF_ISO;
            ST_OF_ISO:  step_d = is_pcie ? ST_OF_WAIT : ST_OF_CLK;
            ST_OF_WAIT: step_d = wait_zero ? ST_OF_CLK : ST_OF_WAIT;
            ST_OF_CLK:  step_d = ST_OF_RST;
            ST_OF_RST:  step_d = ST_OF_PWR2;
            ST_OF_PWR2: step_d = ST_OF_PWR;
            ST_OF_PWR:  step_d = ST_IDLE;
            default:    step_d = ST_IDLE;
        endcase
    end

    // Wait counter control: load on entry, run while in a wait step.
    always_comb begin
        wait_load = ((step_d == ST_ON_WAIT) && (step_q != ST_ON_WAIT)) ||
                    ((step_d == ST_OF_WAIT) && (step_q != ST_OF_WAIT));
        wait_val  = (step_d == ST_ON_WAIT) ? CW'(ON_WAIT_CYC - 1) : CW'(OFF_WAIT_CYC - 1);
        wait_run  = (step_q == ST_ON_WAIT) || (step_q == ST_OF_WAIT);
    end

    retn_wait_cnt #(.W(CW)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wait_load),
        .load_val_i (wait_val),
        .run_i      (wait_run),
        .zero_o     (wait_zero)
    );

    // State, captured type and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
            dom_q  <= DOM_PLAIN;
            done_q <= 1'b0;
        end else begin
            step_q <= step_d;
            done_q <= (step_q != ST_IDLE) && (step_d == ST_IDLE);
            if (step_q == ST_IDLE) dom_q <= dom_i;
        end
    end

    assign step_o = step_q;
    assign dom_o  = dom_q;
    assign busy_o = (step_q != ST_IDLE);
    assign done_o = done_q;

    // R11: done lasts a single cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R11: done only while not busy
    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (step_q == ST_IDLE));
    // R12: captured type does not move during a sequence
    a_r12_type_held: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != ST_IDLE) |=> (dom_q == $past(dom_q)));
    // R3: power-up settle wait holds until the counter expires
    a_r3_on_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_ON_WAIT && !wait_zero) |=> (step_q == ST_ON_WAIT));
    // R4: no retention hardware means no restore
    a_r4_plain_no_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_ON_CHK && dom_q == DOM_PLAIN) |=> (step_q == ST_IDLE));

endmodule

// File: rtl/retn_ctl_word.sv
// Domain control word register.
// Applies the set/clear masks of the current step each clock and holds
// its value while idle. Resets to the powered-off, isolated pattern.
module retn_ctl_word
    import retn_pd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step_i,
    input  dom_type_e        dom_i,
    output logic [CTL_W-1:0] ctl_o
);

    mask_t            m;
    logic [CTL_W-1:0] ctl_q;

    // Decode the current step into bit actions.
    always_comb m = step_mask(step_i, dom_i);

    // Control word update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q            <= '0;
            ctl_q[B_ISO]     <= 1'b1;
            ctl_q[B_CLKOFF]  <= 1'b1;
            ctl_q[B_RNRST]   <= 1'b1;
        end else begin
            ctl_q <= (ctl_q & ~m.clr) | m.set;
        end
    end

    assign ctl_o = ctl_q;

    // R2: reset is released only with isolation and clock gate removed
    a_r2_release_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q[B_RSTN]) |-> (!ctl_q[B_ISO] && !ctl_q[B_CLKOFF]));
    // R5: restore pulse happens with a retention clock gated
    a_r5_restore_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q[B_RNRST]) |-> (ctl_q[B_RCLKOFF] || ctl_q[B_UCLKOFF]));
    // R8: save pulse happens with a retention clock gated
    a_r8_save_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q[B_RSAVE]) |-> (ctl_q[B_RCLKOFF] || ctl_q[B_UCLKOFF]));
    // R10: reset asserted only behind isolation
    a_r10_iso_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q[B_RSTN]) |-> ctl_q[B_ISO]);

endmodule

// File: rtl/retn_pd_seq.sv
// Retention-aware power domain sequencer, top level.
// Derives the settle-wait cycle counts from the clock frequency and
// joins the step sequencer with the control word register.
// Assumes CLK_MHZ*ON_SETTLE_US and CLK_MHZ*OFF_SETTLE_US are >= 1.
module retn_pd_seq
    import retn_pd_pkg::*;
#(
    parameter int CLK_MHZ       = 125,
    parameter int ON_SETTLE_US  = 5,
    parameter int OFF_SETTLE_US = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       dom_type_i,
    input  logic             on_req_i,
    input  logic             off_req_i,
    input  logic             saved_flag_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int ON_WAIT_CYC  = CLK_MHZ * ON_SETTLE_US;
    localparam int OFF_WAIT_CYC = CLK_MHZ * OFF_SETTLE_US;

    step_e     step;
    dom_type_e dom_q;
    dom_type_e dom_in;

    // Map the raw type pins onto the type encoding.
    always_comb dom_in = dom_type_e'(dom_type_i);

    retn_seq_fsm #(
        .ON_WAIT_CYC  (ON_WAIT_CYC),
        .OFF_WAIT_CYC (OFF_WAIT_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dom_i        (dom_in),
        .on_req_i     (on_req_i),
        .off_req_i    (off_req_i),
        .saved_flag_i (saved_flag_i),
        .step_o       (step),
        .dom_o        (dom_q),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    retn_ctl_word u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .dom_i  (dom_q),
        .ctl_o  (ctl_o)
    );

endmodule

// File: tb/retn_pd_seq_bench.sv
`timescale 1ns/1ps
module retn_pd_seq_bench;

    localparam int ON_N  = 125 * 5;
    localparam int OFF_N = 125 * 1;
    localparam logic [31:0] RST_WORD = 32'h0200_000C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  dom_type;
    logic        on_req, off_req, saved_flag;
    logic [31:0] ctl_o;
    logic        busy_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] exp_w [64];
    int          exp_t [64];
    int          n_exp, exp_done, chk_t, mt;
    logic [31:0] mw;
    logic [31:0] got_w [64];
    int          got_t [64];
    int          n_got;

    always #4 clk = ~clk;

    retn_pd_seq u_retn_pd_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .dom_type_i   (dom_type),
        .on_req_i     (on_req),
        .off_req_i    (off_req),
        .saved_flag_i (saved_flag),
        .ctl_o        (ctl_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Model one step: time advances one cycle, word updates.
    task automatic mstep(input int sb, input int cb);
        logic [31:0] nw;
        mt++;
        nw = mw;
        if (sb >= 0) nw[sb] = 1'b1;
        if (cb >= 0) nw[cb] = 1'b0;
        if (nw != mw && n_exp < 64) begin
            exp_w[n_exp] = nw;
            exp_t[n_exp] = mt;
            n_exp++;
        end
        mw = nw;
    endtask

    // Expected change list from the requirements.
    task automatic model(input bit is_on, input int ty, input bit f);
        bit rest;
        n_exp = 0; mt = 1; chk_t = -1;
        if (is_on) begin
            mstep(0, -1); mstep(1, -1);
            if (ty == 2) mstep(26, -1);
            mstep(-1, 3); mstep(-1, 2);
            if (ty == 2) mt += ON_N;
            mstep(4, -1);
            chk_t = mt;
            mt++;
            rest = (ty == 3) || ((ty == 1 || ty == 2) && f);
            if (rest) begin
                if (ty == 1) begin
                    mstep(-1, 27); mstep(26, -1); mstep(-1, 25); mstep(25, -1); mstep(-1, 26);
                end else if (ty == 2) begin
                    mstep(-1, 27); mstep(-1, 25); mstep(25, -1); mstep(-1, 26);
                end else begin
                    mstep(28, -1); mstep(-1, 25); mstep(25, -1); mstep(-1, 28);
                end
            end
        end else begin
            if (ty == 1 || ty == 2) begin
                mstep(26, -1); mstep(24, -1); mstep(-1, 24); mstep(-1, 26); mstep(27, -1);
            end else if (ty == 3) begin
                mstep(28, -1); mstep(24, -1); mstep(-1, 24); mstep(-1, 28);
            end
            mstep(2, -1);
            if (ty == 2) mt += OFF_N;
            mstep(3, -1); mstep(-1, 4); mstep(-1, 1); mstep(-1, 0);
        end
        exp_done = mt;
    endtask

    function automatic string tag_of(input bit is_on, input int ty, input bit f);
        if (is_on) begin
            case (ty)
                0: return "R2";
                1: return f ? "R5" : "R4";
                2: return f ? "R6" : "R3";
                default: return "R7";
            endcase
        end
        case (ty)
            0: return "R9";
            1: return "R8";
            2: return "R10";
            default: return "R9";
        endcase
    endfunction

    // One sequence with optional stray requests while busy.
    task automatic run_seq(input bit is_on, input int ty, input bit f,
                           input bit inj, input bit both);
        int    cnt, inj_at, done_at, bad_i;
        bit    seen_done, busy_bad, ok;
        logic [31:0] prev;
        string tg;
        model(is_on || both, ty, f);
        tg = (inj || both) ? {tag_of(is_on || both, ty, f), "/R12"} : tag_of(is_on || both, ty, f);
        n_got = 0; busy_bad = 0; seen_done = 0; done_at = -1; cnt = 0;
        @(negedge clk);
        dom_type   = ty[1:0];
        saved_flag = f;
        on_req     = is_on || both;
        off_req    = !is_on || both;
        prev       = ctl_o;
        inj_at     = inj ? 2 + int'($urandom_range(exp_done - 4, 0)) : -10;
        while (!seen_done && cnt < exp_done + 4) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1) begin
                on_req = 1'b0; off_req = 1'b0;
                if (inj) dom_type = 2'($urandom_range(3, 0));
            end
            if (cnt == inj_at) begin
                on_req = 1'b1; off_req = 1'($urandom_range(1, 0));
            end else if (cnt == inj_at + 1) begin
                on_req = 1'b0; off_req = 1'b0;
            end
            if (chk_t >= 0 && cnt == chk_t + 1) saved_flag = ~f;
            if (ctl_o != prev) begin
                if (n_got < 64) begin
                    got_w[n_got] = ctl_o; got_t[n_got] = cnt;
                end
                n_got++;
            end
            prev = ctl_o;
            if (done_o) begin seen_done = 1; done_at = cnt; end
            if (busy_o != (cnt < exp_done)) busy_bad = 1;
        end
        ok = (n_got == n_exp);
        bad_i = -1;
        for (int i = 0; i < n_exp && i < 64; i++)
            if (ok && (got_w[i] != exp_w[i] || got_t[i] != exp_t[i]) && bad_i < 0) bad_i = i;
        if (!ok)
            check(0, tg, "number of control word changes", n_got, n_exp);
        else if (bad_i >= 0)
            check(0, tg, "change word/cycle", {got_w[bad_i], 32'(got_t[bad_i])},
                  {exp_w[bad_i], 32'(exp_t[bad_i])});
        else
            check(1, tg, "order", 0, 0);
        check(seen_done && done_at == exp_done, "R11", "done cycle", done_at, exp_done);
        check(!busy_bad, "R11", "busy window", busy_bad, 0);
        @(negedge clk);
        check(!done_o && ctl_o == mw, "R11", "done pulse / held word",
              {31'd0, done_o, ctl_o}, {32'd0, mw});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; dom_type = 2'd0; on_req = 1'b0; off_req = 1'b0; saved_flag = 1'b0;
        on_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ctl_o == RST_WORD && !busy_o && !done_o, "R1", "word in reset",
              ctl_o, RST_WORD);
        on_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(ctl_o == RST_WORD && !busy_o && !done_o, "R1", "word after reset",
              {busy_o, done_o, ctl_o}, {2'b00, RST_WORD});
        mw = RST_WORD;

        // Directed: each type, both flag values, up and down.
        for (int ty = 0; ty < 4; ty++) begin
            run_seq(1, ty, 1'b0, 0, 0);
            run_seq(0, ty, 1'b0, 0, 0);
            run_seq(1, ty, 1'b1, 0, 0);
            run_seq(0, ty, 1'b1, 0, 0);
        end
        // Directed: both requests from idle, power-up wins (R12).
        run_seq(0, 1, 1'b1, 0, 1);
        run_seq(0, 2, 1'b1, 0, 0);

        // Random mix with stray requests while busy.
        for (int k = 0; k < 40; k++) begin
            run_seq(1'($urandom_range(1, 0)), int'($urandom_range(3, 0)),
                    1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule